// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block is the synchronous front end of a word-wide read-only memory that delivers data in bursts. A starting word address is captured on a clock edge while the active-low load strobe is asserted. After that, each clock edge that sees the active-low advance strobe asserted moves the output one word further through a 32-word burst. The offset into the burst is kept modulo 32, so the advance after the 32nd word returns to the exact word that was loaded. It does not return to an aligned boundary.

An active-low end-of-burst output marks the 32nd word of the burst. The current word address goes to a behavioural memory whose content is a fixed function of the address. The 16-bit data output is driven only while the chip is selected, the output is enabled, the write strobe is inactive and a start address has been loaded since reset. Chip select, output enable and write strobe gate the data path without a clock. The burst position is unaffected by output enable and write strobe. Chip select only decides whether advance strobes are taken.

Top module: `burst_seq`

## Requirements
- R1: While reset is low, and afterwards until the first load, `cur_addr` is 0, `end_n` is 1, `dq_oe` is 0 and `dq_out` is 0. An advance strobe before the first load changes nothing.
- R2: A rising edge with `load_n` low captures `addr` as the start word, whatever the state of `ce_n`. `cur_addr` equals that address from that edge on.
- R3: With `load_n` high, the value on `addr` has no effect on `cur_addr`.
- R4: After a load, a rising edge with `load_n` high, `adv_n` low and `ce_n` low increments `cur_addr` by one, modulo 2^19.
- R5: A rising edge with `load_n` high and `adv_n` high leaves `cur_addr` unchanged.
- R6: `end_n` is 0 exactly while `cur_addr` equals start + 31 (mod 2^19), that is, on the 32nd word of the burst. Otherwise it is 1.
- R7: An advance while on the 32nd word returns `cur_addr` to the loaded start word, and `end_n` goes back to 1.
- R8: When `load_n` and `adv_n` are both low on the same edge, the load wins: `cur_addr` becomes `addr` and the burst offset restarts at 0.
- R9: While `ce_n` is high, advance strobes are ignored.
- R10: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0, `we_n`=1 and a load has occurred since reset. It responds without a clock. While `dq_oe` is 0, `dq_out` is 0. Toggling `oe_n` or `we_n` never moves the burst position.
- R11: While driven, `dq_out` = `cur_addr[15:0]` XOR {`cur_addr[18:16]`, 13'b0} XOR 16'h5A3C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 19 | Start word address, sampled when the load strobe is low |
| load_n | input | 1 | Active-low load strobe |
| adv_n | input | 1 | Active-low advance strobe |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe; blocks the data output while low |
| cur_addr | output | 19 | Current word address in the burst |
| end_n | output | 1 | Low on the last (32nd) word of the burst |
| dq_out | output | 16 | Read data; 0 when not driven |
| dq_oe | output | 1 | High when `dq_out` is being driven |

## Verification
The bench builds the block with its default parameters: a 19-bit address, a 16-bit word and a 32-word burst. With these values, one burst of 31 advances reaches the end marker, and one more advance shows the return to the start word. A start address just below 2^19 shows the address rolling over through zero within a burst. A start address of 0x3FFF0 takes the burst across a carry in the upper address bits, so the wrap must return to the loaded word, not to an aligned one.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int BURST_LEN = 32,
  parameter logic [DATA_W-1:0] DATA_KEY = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              end_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int OFF_W = $clog2(BURST_LEN);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BURST_LEN - 1);

  logic [ADDR_W-1:0] start_q;
  logic [OFF_W-1:0]  off_q;
  logic              valid_q;

  wire do_load = !load_n;
  wire do_step = load_n && !adv_n && !ce_n && valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      off_q   <= '0;
      valid_q <= 1'b0;
    end else if (do_load) begin
      start_q <= addr;
      off_q   <= '0;
      valid_q <= 1'b1;
    end else if (do_step) begin
      off_q <= off_q + 1'b1;
    end
  end

  assign cur_addr = start_q + ADDR_W'(off_q);
  assign end_n    = !(off_q == LAST);

  wire [DATA_W-1:0] mem_word =
    cur_addr[DATA_W-1:0] ^ {cur_addr[ADDR_W-1:DATA_W], {(DATA_W-HI_W){1'b0}}} ^ DATA_KEY;

  assign dq_oe  = !ce_n && !oe_n && we_n && valid_q;
  assign dq_out = dq_oe ? mem_word : '0;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (cur_addr == $past(addr)) && end_n); // R2
  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n && !adv_n) |=> off_q == '0); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && adv_n) |=> $stable(cur_addr)); // R5
  AST_DESELECT_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && ce_n) |=> $stable(cur_addr)); // R9
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !adv_n && !ce_n && valid_q && end_n) |=> cur_addr == $past(cur_addr) + 1'b1); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !adv_n && !ce_n && !end_n) |=> (cur_addr == $past(start_q)) && end_n); // R7
  AST_END_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !end_n |-> cur_addr == start_q + ADDR_W'(BURST_LEN - 1)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0); // R10
  AST_NO_DRIVE_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> !dq_oe && cur_addr == '0); // R1
endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [18:0] addr = '0;
  logic load_n = 1'b1, adv_n = 1'b1, ce_n = 1'b0, oe_n = 1'b0, we_n = 1'b1;
  logic [18:0] cur_addr;
  logic end_n, dq_oe;
  logic [15:0] dq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  burst_seq uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load_n(load_n), .adv_n(adv_n),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .cur_addr(cur_addr), .end_n(end_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {load_n, adv_n, ce_n, addr, expected cur_addr, expected end_n}
  localparam logic [41:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 1'b0, 19'h12345, 19'h12345, 1'b1},
    {1'b1, 1'b0, 1'b0, 19'h00000, 19'h12346, 1'b1},
    {1'b1, 1'b1, 1'b0, 19'h7FFFF, 19'h12346, 1'b1},
    {1'b1, 1'b0, 1'b1, 19'h00000, 19'h12346, 1'b1},
    {1'b1, 1'b0, 1'b0, 19'h55555, 19'h12347, 1'b1},
    {1'b0, 1'b0, 1'b0, 19'h00100, 19'h00100, 1'b1},
    {1'b1, 1'b0, 1'b0, 19'h00000, 19'h00101, 1'b1},
    {1'b0, 1'b1, 1'b0, 19'h7FFFE, 19'h7FFFE, 1'b1},
    {1'b1, 1'b0, 1'b0, 19'h00000, 19'h7FFFF, 1'b1},
    {1'b1, 1'b0, 1'b0, 19'h00000, 19'h00000, 1'b1},
    {1'b1, 1'b0, 1'b0, 19'h00000, 19'h00001, 1'b1},
    {1'b0, 1'b1, 1'b1, 19'h2AAAA, 19'h2AAAA, 1'b1}
  };
  localparam string VTAG [0:NV-1] = '{"R2", "R4", "R3 R5", "R9", "R4", "R8",
                                      "R4", "R2", "R4", "R4", "R4", "R2"};

  function automatic logic [15:0] word_of(input logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'b0} ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic ld, input logic av, input logic ce, input logic [18:0] a);
    @(negedge clk);
    load_n = ld; adv_n = av; ce_n = ce; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset addr", 32'(cur_addr), 32'h0);
    chk("R1 reset end", 32'(end_n), 32'h1);
    chk("R1 reset oe", 32'(dq_oe), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b1, 1'b0, 1'b0, 19'h11111);
    chk("R1 advance before load", 32'(cur_addr), 32'h0);
    chk("R1 no drive before load", 32'(dq_oe), 32'h0);
    chk("R1 idle data", 32'(dq_out), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      tick(v[41], v[40], v[39], v[38:20]);
      chk({VTAG[i], " addr"}, 32'(cur_addr), 32'(v[19:1]));
      chk({"R6 end ", VTAG[i]}, 32'(end_n), 32'(v[0]));
      chk({"R10 oe ", VTAG[i]}, 32'(dq_oe), 32'(!v[39]));
      chk({"R11 data ", VTAG[i]}, 32'(dq_out), v[39] ? 32'h0 : 32'(word_of(v[19:1])));
    end

    // full burst across an upper-bit carry, then wrap back to the start word
    tick(1'b0, 1'b1, 1'b0, 19'h3FFF0);
    for (int i = 1; i < 32; i++) begin
      tick(1'b1, 1'b0, 1'b0, 19'h0);
      chk("R4 burst addr", 32'(cur_addr), 32'h3FFF0 + 32'(i));
      chk("R6 burst end", 32'(end_n), (i == 31) ? 32'h0 : 32'h1);
    end
    tick(1'b1, 1'b1, 1'b0, 19'h0);
    chk("R5 hold on last word", 32'(end_n), 32'h0);
    tick(1'b1, 1'b0, 1'b0, 19'h0);
    chk("R7 wrap addr", 32'(cur_addr), 32'h3FFF0);
    chk("R7 wrap end", 32'(end_n), 32'h1);
    tick(1'b1, 1'b0, 1'b0, 19'h0);
    chk("R4 after wrap", 32'(cur_addr), 32'h3FFF1);

    // output gating is combinational and leaves the position alone
    @(negedge clk);
    load_n = 1'b1; adv_n = 1'b1;
    oe_n = 1'b1; #1;
    chk("R10 oe_n high", 32'(dq_oe), 32'h0);
    chk("R10 oe_n high data", 32'(dq_out), 32'h0);
    oe_n = 1'b0; we_n = 1'b0; #1;
    chk("R10 we_n low", 32'(dq_oe), 32'h0);
    we_n = 1'b1; #1;
    chk("R10 restored", 32'(dq_oe), 32'h1);
    chk("R11 restored data", 32'(dq_out), 32'(word_of(19'h3FFF1)));
    ce_n = 1'b1; #1;
    chk("R10 ce_n high", 32'(dq_oe), 32'h0);
    ce_n = 1'b0;
    tick(1'b1, 1'b0, 1'b0, 19'h0);
    chk("R10 position kept", 32'(cur_addr), 32'h3FFF2);

    // reset mid-burst
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 mid reset addr", 32'(cur_addr), 32'h0);
    chk("R1 mid reset oe", 32'(dq_oe), 32'h0);
    chk("R1 mid reset end", 32'(end_n), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b1, 1'b0, 1'b0, 19'h0);
    chk("R1 advance after reset", 32'(cur_addr), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule